// File: doc/BRIEF.md
# Shared-Bus Register Transfer Bank

This block holds three 8-bit storage registers, numbered 1 to 3, and one external 8-bit input port that is addressed as unit 0. All four units meet on one internal 8-bit bus. A 2-bit source code picks the unit that drives the bus. A 2-bit target code picks the register that takes the bus value at the next rising clock edge. With these two codes a value can be loaded from the input port into any register, or copied from one register to another. The bus value is also presented on a display output, so the contents of any unit can be read out.

Each storage register is built as an 8-bit cell with two active-low load enables and two active-low drive enables. The source and target codes are decoded one-hot into those enables. The bus is a one-hot-selected AND-OR multiplexer, so the block needs no tri-state logic. An active-low asynchronous clear sets all registers to zero. The clear is released synchronously inside the block.

Top module: `xfer_bank`

## Requirements
- R1: After the clear (`rst_n` low), all three registers read 0. This is observed by selecting each one as the source.
- R2: With source code 0, the bus and `bus_o` equal `key_i` in the same cycle, combinationally.
- R3: With source code k (1 to 3), `bus_o` equals the current contents of register k.
- R4: When `wr_en_i` is high and the target code is k (1 to 3), register k takes the bus value on the rising edge.
- R5: A transfer writes only the target register. The other two registers keep their values.
- R6: Target code 0 names the input port, which cannot be written, so no register changes on that edge.
- R7: When `wr_en_i` is low, no register changes, whatever the target code.
- R8: When source and target are the same register, that register reloads its own value and stays unchanged.
- R9: The source and target decoders each enable at most one unit, and the source decoder enables exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous clear |
| key_i | input | 8 | External input value (unit 0) |
| src_sel_i | input | 2 | Source unit code driving the bus |
| dst_sel_i | input | 2 | Target unit code written on the next edge |
| wr_en_i | input | 1 | Transfer strobe |
| bus_o | output | 8 | Current bus value for display |

## Verification
The bench first loads distinct values from the input port into each register. A wrong decode then shows up as a mismatched value rather than passing unnoticed. It then runs register-to-register copies in both directions and copies of a register onto itself, and it also tries target code 0 and a low strobe, which must leave the contents alone. A final phase drives random source, target and strobe combinations with random input values. A reference array in the bench is checked against `bus_o` every cycle, and each register is also read back explicitly.

// File: rtl/xfer_bank_pkg.sv
package xfer_bank_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned N_UNITS = 1 << SEL_W;
  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [N_UNITS-1:0] onehot_t;
endpackage

// File: rtl/xfer_sel_dec.sv
module xfer_sel_dec #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N-1:0]     hot_o
);
  always_comb begin
    hot_o = '0;
    if (en_i) hot_o[sel_i] = 1'b1;
  end
endmodule

// File: rtl/xfer_reg_cell.sv
module xfer_reg_cell #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  input  logic              oe_a_n,
  input  logic              oe_b_n,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o,
  output logic              drv_o
);
  logic [DATA_W-1:0] q_r, q_nxt;
  logic              ld_en;

  assign ld_en = ~ld_a_n & ~ld_b_n;

  always_comb begin
    q_nxt = q_r;
    if (ld_en) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign drv_o = ~oe_a_n & ~oe_b_n;
  assign q_o   = drv_o ? q_r : '0;
endmodule

// File: rtl/xfer_bank.sv
module xfer_bank
  import xfer_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DATA_W-1:0] key_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [SEL_W-1:0]  dst_sel_i,
  input  logic             wr_en_i,
  output logic [DATA_W-1:0] bus_o
);
  logic    rst_q1, rst_q2;
  onehot_t src_hot, dst_hot;
  word_t   unit_out [N_UNITS];
  logic [N_UNITS-1:0] unit_drv;
  word_t   bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  xfer_sel_dec #(.SEL_W(SEL_W)) u_src_dec (
    .en_i(1'b1), .sel_i(src_sel_i), .hot_o(src_hot));
  xfer_sel_dec #(.SEL_W(SEL_W)) u_dst_dec (
    .en_i(wr_en_i), .sel_i(dst_sel_i), .hot_o(dst_hot));

  assign unit_out[0] = src_hot[0] ? key_i : '0;
  assign unit_drv[0] = src_hot[0];

  for (genvar g = 1; g < N_UNITS; g++) begin : g_reg
    xfer_reg_cell #(.DATA_W(DATA_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_q2),
      .ld_a_n(~dst_hot[g]),
      .ld_b_n(~wr_en_i),
      .oe_a_n(~src_hot[g]),
      .oe_b_n(1'b0),
      .d_i   (bus),
      .q_o   (unit_out[g]),
      .drv_o (unit_drv[g])
    );
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < N_UNITS; i++) bus = bus | unit_out[i];
  end

  assign bus_o = bus;
endmodule

// File: rtl/xfer_bank_chk.sv
module xfer_bank_chk
  import xfer_bank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] key_i,
  input logic [SEL_W-1:0]  src_sel_i,
  input logic [SEL_W-1:0]  dst_sel_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] bus_o,
  input logic [N_UNITS-1:0] src_hot,
  input logic [N_UNITS-1:0] dst_hot
);
  // R2
  key_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel_i == '0) |-> (bus_o == key_i));
  // R9
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_hot) == 1);
  // R9
  dst_onehot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dst_hot));
  // R7
  no_wr_no_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |-> (dst_hot == '0));
  // R8
  self_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && src_sel_i == dst_sel_i && src_sel_i != '0)
    |=> (src_sel_i == $past(src_sel_i)) |-> $stable(bus_o));
endmodule

bind xfer_bank xfer_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .key_i(key_i), .src_sel_i(src_sel_i),
  .dst_sel_i(dst_sel_i), .wr_en_i(wr_en_i), .bus_o(bus_o),
  .src_hot(src_hot), .dst_hot(dst_hot));

// File: tb/xfer_bank_tb.sv
module xfer_bank_tb;
  localparam time CLK_P = 10;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] key = 0;
  logic [1:0] src = 0, dst = 0;
  logic [7:0] bus;
  int errs = 0, checks = 0;
  logic [7:0] model [4];

  xfer_bank u_dut (.clk(clk), .rst_n(rst_n), .key_i(key), .src_sel_i(src),
                   .dst_sel_i(dst), .wr_en_i(wr_en), .bus_o(bus));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] exp_bus();
    return (src == 0) ? key : model[src];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: set inputs at negedge, check bus, update model at posedge
  task automatic step(logic [1:0] s, logic [1:0] d, logic w, logic [7:0] k, string req);
    @(negedge clk);
    src = s; dst = d; wr_en = w; key = k;
    #1 chk(req, bus, exp_bus());
    @(posedge clk);
    if (w && d != 0) model[d] = exp_bus();
  endtask

  task automatic readback(string req);
    for (int r = 1; r < 4; r++) step(2'(r), 0, 0, 8'h00, req);
  endtask

  initial begin
    #(CLK_P*5000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    readback("R1");
    step(0, 0, 0, 8'h5A, "R2");
    step(0, 0, 0, 8'hC3, "R2");
    step(0, 1, 1, 8'h11, "R4");
    step(0, 2, 1, 8'h22, "R4");
    step(0, 3, 1, 8'h33, "R4");
    readback("R3");
    step(1, 2, 1, 8'hFF, "R5");   // R2 <- R1
    readback("R5");
    step(3, 1, 1, 8'hFF, "R5");   // R1 <- R3
    readback("R5");
    step(0, 0, 1, 8'hEE, "R6");
    readback("R6");
    for (int d = 0; d < 4; d++) step(0, 2'(d), 0, 8'h99, "R7");
    readback("R7");
    for (int r = 1; r < 4; r++) begin
      step(2'(r), 2'(r), 1, 8'h77, "R8");
      step(2'(r), 0, 0, 8'h77, "R8");
    end
    for (int n = 0; n < 300; n++)
      step(2'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), "R4");
    readback("R5");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule